// File: doc/BRIEF.md
# Temperature Conversion Scheduler with Standby Control

This block decides when a two-channel temperature conversion runs. In normal operation it starts conversions at a fixed period, which a 3-bit rate code selects. Each conversion measures the local channel and then the remote channel. Every channel result is the average of several back-to-back measurements taken from an ADC through a start/done handshake. When a channel's average is ready, the block pulses a write enable for that channel's value register and presents the result alongside it.

Standby has two sources. Pulling the standby pin low blocks all conversions. Setting the configuration standby level stops periodic conversions but still lets a one-shot request run exactly one conversion of both channels. Entering either standby while a conversion is in flight aborts that conversion, and its result is never written. The remote open-circuit detector input is captured once, at the start of each conversion.

Top module: `conv_sched`

## Requirements
- R1: After reset, `rate_o` reads 02h, and `busy_o`, `loc_we_o`, `rem_we_o`, `abort_o` and `open_o` are low.
- R2: A rate write is accepted only when `rate_wdata_i[7:3]` is zero. Any other write leaves `rate_o` unchanged. `rate_o[7:3]` is always zero.
- R3: While running, conversions start every 2^(7-c) ticks, where c is `rate_o[2:0]` and one tick is `TICK_DIV` clock cycles. Code 00h gives 128 ticks and code 07h gives 1 tick.
- R4: A channel result is the floor of the sum of `NUM_AVG` consecutive signed 8-bit (two's complement) ADC samples divided by `NUM_AVG`. It appears on `result_o` in the same cycle as that channel's write enable.
- R5: Each conversion measures channel 0 (local, `adc_chan_o`=0) first, then channel 1 (remote). `loc_we_o` pulses before `rem_we_o`, and `busy_o` is high from the first ADC start until the remote result has been written.
- R6: Driving `stby_ni` low while a conversion is busy raises `abort_o` in that cycle. `busy_o` then falls at the next edge, and no write enable follows for that conversion. While the pin stays low, no conversion runs.
- R7: A rising edge of `cfg_stby_i` during a busy conversion aborts it. While `cfg_stby_i` is high, no periodic conversion starts, but a `oneshot_i` pulse runs exactly one two-channel conversion and the block then stays idle.
- R8: A `oneshot_i` pulse in run mode (pin high and `cfg_stby_i` low) starts no conversion.
- R9: A `oneshot_i` pulse while `stby_ni` is low starts no conversion, whatever the value of `cfg_stby_i`.
- R10: `open_o` takes the value of `open_i` in the cycle a conversion starts and holds it until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_ni | input | 1 | Hardware standby pin, low = standby |
| cfg_stby_i | input | 1 | Software standby level from the configuration register |
| rate_wr_i | input | 1 | Rate register write strobe |
| rate_wdata_i | input | 8 | Rate register write data |
| oneshot_i | input | 1 | One-shot conversion request pulse |
| open_i | input | 1 | Remote open-circuit detector output |
| adc_done_i | input | 1 | ADC measurement complete pulse |
| adc_data_i | input | 8 | ADC sample, two's complement |
| rate_o | output | 8 | Rate register readback |
| busy_o | output | 1 | Conversion in progress |
| adc_start_o | output | 1 | ADC measurement start pulse |
| adc_chan_o | output | 1 | Channel being measured, 0 local, 1 remote |
| abort_o | output | 1 | Conversion aborted by standby entry |
| loc_we_o | output | 1 | Local value register write enable |
| rem_we_o | output | 1 | Remote value register write enable |
| result_o | output | 8 | Averaged channel result |
| open_o | output | 1 | Open-circuit flag captured at conversion start |

## Verification
The assertions assume the ADC answers each start with exactly one done pulse and sends no done while no measurement is outstanding. They also assume the standby pin is a clean level held for whole clock cycles. The bench ADC model keeps to this: it has one pending request at a time, it drops that request when `abort_o` is seen, and it returns data after a fixed latency. Sample values stay small enough that adding the 0..3 offset never wraps 8 bits. All standby and request inputs change only on the falling clock edge, and the tick period is longer than one full conversion, so a periodic start never lands while a conversion is still running.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef logic signed [7:0] temp_t;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_st_e;
endpackage

// File: rtl/conv_tick.sv
module conv_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == TW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_rate.sv
module conv_rate #(
  parameter int RATE_BITS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       run_i,
  input  logic       tick_i,
  output logic [7:0] rate_o,
  output logic       fire_o
);
  localparam int CW = 2**RATE_BITS - 1;
  logic [RATE_BITS-1:0] code_q;
  logic [CW-1:0]        cnt_q, lim;

  assign rate_o = {{(8-RATE_BITS){1'b0}}, code_q};
  // period in ticks = lim + 1 = 2^(CW - code)
  assign lim    = {CW{1'b1}} >> code_q;
  assign fire_o = run_i && tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RATE_BITS'(2);
      cnt_q  <= '0;
    end else begin
      if (wr_i && (wdata_i[7:RATE_BITS] == '0)) code_q <= wdata_i[RATE_BITS-1:0];
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv_avg.sv
module conv_avg import conv_pkg::*; #(
  parameter int NUM_AVG = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  add_i,
  input  temp_t data_i,
  output temp_t avg_o
);
  localparam int SH = $clog2(NUM_AVG);
  localparam int AW = 8 + SH;
  logic signed [AW-1:0] acc_q, sum_nx;

  assign sum_nx = acc_q + {{SH{data_i[7]}}, data_i};
  assign avg_o  = temp_t'(sum_nx >>> SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= sum_nx;
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq import conv_pkg::*; #(
  parameter int NUM_AVG = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  logic  abort_i,
  input  logic  done_i,
  input  temp_t avg_i,
  output logic  busy_o,
  output logic  start_o,
  output logic  ch_o,
  output logic  add_o,
  output logic  clr_o,
  output logic  loc_we_o,
  output logic  rem_we_o,
  output temp_t res_o
);
  localparam int NW = (NUM_AVG > 2) ? $clog2(NUM_AVG) : 1;
  seq_st_e       st_q;
  logic [NW-1:0] n_q;
  logic          last;

  assign last    = (n_q == NW'(NUM_AVG - 1));
  assign busy_o  = (st_q != ST_IDLE);
  assign start_o = (st_q == ST_REQ) && !abort_i;
  assign add_o   = (st_q == ST_WAIT) && done_i && !abort_i;
  assign clr_o   = ((st_q == ST_IDLE) && go_i) || (add_o && last && !ch_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      n_q      <= '0;
      ch_o     <= 1'b0;
      loc_we_o <= 1'b0;
      rem_we_o <= 1'b0;
      res_o    <= '0;
    end else begin
      loc_we_o <= 1'b0;
      rem_we_o <= 1'b0;
      if (abort_i) st_q <= ST_IDLE;
      else unique case (st_q)
        ST_IDLE: if (go_i) begin
          st_q <= ST_REQ;
          ch_o <= 1'b0;
          n_q  <= '0;
        end
        ST_REQ:  st_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (last) begin
            res_o <= avg_i;
            n_q   <= '0;
            if (!ch_o) begin
              loc_we_o <= 1'b1;
              ch_o     <= 1'b1;
              st_q     <= ST_REQ;
            end else begin
              rem_we_o <= 1'b1;
              st_q     <= ST_IDLE;
            end
          end else begin
            n_q  <= n_q + 1'b1;
            st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_sched.sv
module conv_sched import conv_pkg::*; #(
  parameter int TICK_DIV  = 1000,
  parameter int NUM_AVG   = 16,
  parameter int RATE_BITS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_ni,
  input  logic       cfg_stby_i,
  input  logic       rate_wr_i,
  input  logic [7:0] rate_wdata_i,
  input  logic       oneshot_i,
  input  logic       open_i,
  input  logic       adc_done_i,
  input  logic [7:0] adc_data_i,
  output logic [7:0] rate_o,
  output logic       busy_o,
  output logic       adc_start_o,
  output logic       adc_chan_o,
  output logic       abort_o,
  output logic       loc_we_o,
  output logic       rem_we_o,
  output logic [7:0] result_o,
  output logic       open_o
);
  logic  tick, fire, run, hw_stby, sw_q, go, clr, add;
  temp_t avg, res;

  assign hw_stby = !stby_ni;
  assign run     = !hw_stby && !cfg_stby_i;
  // pin aborts at any time; software bit only on its rising edge
  assign abort_o = busy_o && (hw_stby || (cfg_stby_i && !sw_q));
  assign go      = !busy_o && (fire || (oneshot_i && cfg_stby_i && !hw_stby));
  assign result_o = res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b0;
      open_o <= 1'b0;
    end else begin
      sw_q <= cfg_stby_i;
      if (go) open_o <= open_i;
    end
  end

  conv_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  conv_rate #(.RATE_BITS(RATE_BITS)) i_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(rate_wr_i), .wdata_i(rate_wdata_i),
    .run_i(run), .tick_i(tick), .rate_o(rate_o), .fire_o(fire)
  );

  conv_avg #(.NUM_AVG(NUM_AVG)) i_avg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .add_i(add),
    .data_i(temp_t'(adc_data_i)), .avg_o(avg)
  );

  conv_seq #(.NUM_AVG(NUM_AVG)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .abort_i(abort_o),
    .done_i(adc_done_i), .avg_i(avg), .busy_o(busy_o), .start_o(adc_start_o),
    .ch_o(adc_chan_o), .add_o(add), .clr_o(clr), .loc_we_o(loc_we_o),
    .rem_we_o(rem_we_o), .res_o(res)
  );
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stby_ni,
  input logic       busy_o,
  input logic       adc_start_o,
  input logic       abort_o,
  input logic       loc_we_o,
  input logic       rem_we_o,
  input logic [7:0] rate_o
);
  assert_rate_resv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_o[7:3] == 5'd0);

  assert_we_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({loc_we_o, rem_we_o}));

  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> busy_o);

  assert_rem_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_we_o |-> !busy_o);

  assert_abort_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!busy_o && !loc_we_o && !rem_we_o));

  assert_pin_no_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_ni && $past(!stby_ni)) |-> (!loc_we_o && !rem_we_o));

  assert_pin_no_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_ni && !busy_o) |=> !busy_o);
endmodule

bind conv_sched conv_sched_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stby_ni(stby_ni), .busy_o(busy_o),
  .adc_start_o(adc_start_o), .abort_o(abort_o), .loc_we_o(loc_we_o),
  .rem_we_o(rem_we_o), .rate_o(rate_o)
);

// File: tb/test_conv_sched.sv
`timescale 1ns/1ps
module test_conv_sched;
  localparam int CLK_P = 10;
  localparam int TICK  = 128;
  localparam int NAVG  = 16;
  localparam int WDOG  = 190000;
  // rate code, local value, remote value
  localparam logic [23:0] VEC [4] = '{
    {8'h07, 8'd25,   8'hC9},
    {8'h05, 8'h80,   8'd100},
    {8'h02, 8'd0,    8'hFF},
    {8'h00, 8'd120,  8'hF6}
  };

  logic clk = 0, rst_n = 0;
  logic stby_n = 1, cfg_stby = 0, rate_wr = 0, oneshot = 0, open_in = 0;
  logic [7:0] rate_wd = 0;
  logic adc_done = 0;
  logic [7:0] adc_data = 0;
  logic [7:0] rate, result;
  logic busy, adc_start, adc_chan, abort_s, loc_we, rem_we, open_out;
  logic signed [7:0] loc_val = 0, rem_val = 0;

  int total = 0, bad = 0, cyc = 0;
  int loc_cnt = 0, rem_cnt = 0, loc_t = 0, rem_t = 0;
  logic [7:0] loc_res = 0, rem_res = 0;
  bit fin = 0;

  always #(CLK_P/2) clk = ~clk;

  conv_sched #(.TICK_DIV(TICK), .NUM_AVG(NAVG), .RATE_BITS(3)) i_conv_sched (
    .clk_i(clk), .rst_ni(rst_n), .stby_ni(stby_n), .cfg_stby_i(cfg_stby),
    .rate_wr_i(rate_wr), .rate_wdata_i(rate_wd), .oneshot_i(oneshot),
    .open_i(open_in), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .rate_o(rate), .busy_o(busy), .adc_start_o(adc_start), .adc_chan_o(adc_chan),
    .abort_o(abort_s), .loc_we_o(loc_we), .rem_we_o(rem_we), .result_o(result),
    .open_o(open_out)
  );

  // ADC model: fixed latency of one cycle, offset 0..3 cycling per sample
  logic pend = 0, s_ch = 0;
  logic [1:0] s_off = 0;
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (abort_s) pend <= 1'b0;
    else if (adc_start) begin
      pend <= 1'b1;
      s_ch <= adc_chan;
    end else if (pend) begin
      pend     <= 1'b0;
      adc_done <= 1'b1;
      adc_data <= (s_ch ? rem_val : loc_val) + 8'(s_off);
      s_off    <= s_off + 2'd1;
    end
  end

  // monitor of write pulses
  always @(posedge clk) begin
    cyc++;
    #1;
    if (loc_we) begin loc_cnt++; loc_t = cyc; loc_res = result; end
    if (rem_we) begin rem_cnt++; rem_t = cyc; rem_res = result; end
  end

  always @(posedge clk) if (cyc > WDOG && !fin) begin
    fin = 1;
    total++; bad++;
    $display("FAIL watchdog: act=%0d exp<=%0d", cyc, WDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_avg(input int v);
    int s = 0;
    for (int k = 0; k < NAVG; k++) s += v + (k % 4);
    return s >>> 4;
  endfunction

  task automatic write_rate(input logic [7:0] d);
    @(negedge clk); rate_wr = 1; rate_wd = d;
    @(negedge clk); rate_wr = 0;
  endtask

  task automatic pulse_oneshot();
    @(negedge clk); oneshot = 1;
    @(negedge clk); oneshot = 0;
  endtask

  task automatic wait_loc(input int lim);
    int s = loc_cnt;
    int c = 0;
    while (loc_cnt == s && c < lim) begin @(negedge clk); c++; end
  endtask

  task automatic wait_rem(input int lim);
    int s = rem_cnt;
    int c = 0;
    while (rem_cnt == s && c < lim) begin @(negedge clk); c++; end
  endtask

  task automatic wait_busy(input int lim);
    int c = 0;
    while (!busy && c < lim) begin @(negedge clk); c++; end
  endtask

  // watch for n cycles, return whether busy was ever seen
  task automatic watch_idle(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen = 1; end
  endtask

  initial begin
    int t0, per, lc, rc;
    bit seen;
    repeat (3) @(negedge clk);
    chk(rate == 8'h02, "R1 rate reset", rate, 2);
    chk({busy, loc_we, rem_we, abort_s, open_out} == 5'b0, "R1 outputs idle",
        {busy, loc_we, rem_we, abort_s, open_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 busy after release", busy, 0);

    write_rate(8'h0C);
    chk(rate == 8'h02, "R2 reserved write ignored", rate, 2);
    write_rate(8'hFF);
    chk(rate == 8'h02, "R2 reserved write ignored", rate, 2);

    // periodic vectors: R3 period, R4 averaging, R5 ordering
    foreach (VEC[i]) begin
      logic [7:0] code;
      code = VEC[i][23:16];
      write_rate(code);
      chk(rate == code, "R2 rate accepted", rate, code);
      loc_val = VEC[i][15:8];
      rem_val = VEC[i][7:0];
      per = (128 >> code) * TICK;
      wait_loc(2 * per + 600);
      t0 = loc_t;
      wait_loc(per + 600);
      chk(loc_t - t0 == per, "R3 period", loc_t - t0, per);
      wait_rem(600);
      chk($signed(loc_res) == exp_avg(loc_val), "R4 local average",
          $signed(loc_res), exp_avg(loc_val));
      chk($signed(rem_res) == exp_avg(rem_val), "R4 remote average",
          $signed(rem_res), exp_avg(rem_val));
      chk(rem_t > loc_t, "R5 local before remote", rem_t, loc_t + 1);
    end
    // last vector at code 0: idle for a long time now
    chk(!busy, "R5 busy low after remote write", busy, 0);
    lc = loc_cnt;
    pulse_oneshot();
    watch_idle(100, seen);
    chk(!seen && loc_cnt == lc, "R8 one-shot ignored in run", seen, 0);

    write_rate(8'h07);
    wait_rem(2 * TICK + 600);
    open_in = 1;
    wait_busy(2 * TICK);
    chk(open_out == 1, "R10 open captured at start", open_out, 1);
    open_in = 0;
    wait_rem(600);
    chk(open_out == 1, "R10 open held during conversion", open_out, 1);
    wait_busy(2 * TICK);
    chk(open_out == 0, "R10 open recaptured", open_out, 0);

    // hardware standby abort
    wait_busy(2 * TICK);
    @(negedge clk); // mid-conversion
    lc = loc_cnt; rc = rem_cnt;
    stby_n = 0;
    #1 chk(abort_s == 1, "R6 abort on pin", abort_s, 1);
    @(negedge clk);
    chk(!busy, "R6 busy drops", busy, 0);
    watch_idle(600, seen);
    chk(!seen && loc_cnt + rem_cnt == lc + rc, "R6 no conversion while pin low",
        loc_cnt + rem_cnt - lc - rc, 0);
    cfg_stby = 1;
    pulse_oneshot();
    watch_idle(100, seen);
    chk(!seen, "R9 one-shot ignored with pin low", seen, 0);
    cfg_stby = 0;
    stby_n = 1;

    // software standby abort and one-shot
    wait_busy(3 * TICK);
    @(negedge clk);
    cfg_stby = 1;
    #1 chk(abort_s == 1, "R7 abort on software standby", abort_s, 1);
    @(negedge clk);
    chk(!busy, "R7 busy drops", busy, 0);
    lc = loc_cnt; rc = rem_cnt;
    watch_idle(600, seen);
    chk(!seen && loc_cnt == lc && rem_cnt == rc, "R7 no periodic conversion",
        loc_cnt + rem_cnt - lc - rc, 0);
    loc_val = -8'sd40;
    rem_val = 8'sd77;
    pulse_oneshot();
    chk(busy == 1, "R7 one-shot starts", busy, 1);
    wait_rem(600);
    chk(loc_cnt == lc + 1 && rem_cnt == rc + 1, "R7 one conversion",
        loc_cnt + rem_cnt - lc - rc, 2);
    chk($signed(loc_res) == exp_avg(-40), "R4 one-shot local",
        $signed(loc_res), exp_avg(-40));
    chk($signed(rem_res) == exp_avg(77), "R4 one-shot remote",
        $signed(rem_res), exp_avg(77));
    watch_idle(600, seen);
    chk(!seen && rem_cnt == rc + 1, "R7 returns to standby", seen, 0);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule